// File: doc/BRIEF.md
# Byte Sum of Absolute Differences Unit

This unit compares two 32-bit words as four packed unsigned bytes. For each byte position it forms the magnitude of the difference between the two operands, then reduces the four magnitudes to one sum through a small adder tree. The sum is returned either alone or added to a 32-bit accumulator operand. This is the core step of block-matching motion search and similar distance metrics.

Whether the accumulator is added is decided by a 4-bit register index that travels with the operation. The index value 15 means "no accumulator"; any other index means the accumulator operand is added. The unit samples its operands on the clock edge where the valid strobe is high. The result and its valid flag appear on the following cycle. The result stays unchanged until the next valid operation.

Top module: `byte_sad_unit`

## Requirements
- R1: After reset, `res_valid` is 0 and `res_sum` is 0.
- R2: `res_valid` is high in exactly the cycle after each cycle in which `op_valid` was high at the clock edge. Back-to-back operations give back-to-back results.
- R3: Byte lane k covers bits 8k+7:8k of both operands (k = 0..3). Each lane contributes |a_k − b_k|, with the bytes taken as unsigned values 0..255.
- R4: Exchanging the two operands gives the same result.
- R5: When `acc_sel` equals 15, the result is the bare sum of the four lane magnitudes. This sum is at most 1020, which is reached when every lane pairs 0xFF with 0x00. `acc_val` has no effect in this case.
- R6: When `acc_sel` is any value other than 15, `acc_val` is added to the lane sum.
- R7: The accumulating addition wraps modulo 2^32.
- R8: While `op_valid` is low, changes on the operand inputs leave `res_sum` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operands are sampled at this edge |
| op_a | input | 32 | First operand, four unsigned bytes |
| op_b | input | 32 | Second operand, four unsigned bytes |
| acc_sel | input | 4 | Accumulator register index; 15 disables accumulation |
| acc_val | input | 32 | Accumulator value |
| res_valid | output | 1 | Result is fresh this cycle |
| res_sum | output | 32 | Sum of absolute differences, plus accumulator if selected |

## Verification
The accumulator add and the largest lane sum can occur in the same cycle. When that happens, the carry out of the tree meets a wrapping 32-bit add. The bench provokes this by pairing all-0xFF with all-0x00 operands while `acc_val` sits just below 2^32. It also sends such operations back to back with idle cycles between them that carry changing operands. Every cycle is compared with a behavioural model that works the byte differences out with integers and truncates to 32 bits. The model therefore judges both the wrap and the hold behaviour.

// File: rtl/sad_pkg.sv
package sad_pkg;
    localparam int SAD_LANES    = 4;
    localparam int SAD_LANE_W   = 8;
    localparam int SAD_IDX_W    = 4;
    localparam int SAD_SKIP_IDX = 15;

    typedef logic [SAD_IDX_W-1:0] acc_sel_t;
endpackage

// File: rtl/sad_lane.sv
module sad_lane #(
    parameter int LANE_W = 8
) (
    input  logic [LANE_W-1:0] lane_a,
    input  logic [LANE_W-1:0] lane_b,
    output logic [LANE_W-1:0] lane_mag
);
    logic [LANE_W:0] diff_ext;

    always_comb begin
        diff_ext = {1'b0, lane_a} - {1'b0, lane_b};
        if (diff_ext[LANE_W]) begin
            lane_mag = LANE_W'(-diff_ext[LANE_W-1:0]);
        end else begin
            lane_mag = diff_ext[LANE_W-1:0];
        end
    end
endmodule

// File: rtl/sad_tree.sv
module sad_tree #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    parameter int SUM_W  = LANE_W + $clog2(LANES)
) (
    input  logic [LANES*LANE_W-1:0] leaf_flat,
    output logic [SUM_W-1:0]        tree_sum
);
    localparam int NODES = 2 * LANES - 1;

    logic [SUM_W-1:0] node [NODES];

    for (genvar k = 0; k < LANES; k++) begin : g_leaf
        assign node[LANES-1+k] = SUM_W'(leaf_flat[k*LANE_W +: LANE_W]);
    end

    for (genvar i = 0; i < LANES - 1; i++) begin : g_add
        assign node[i] = node[2*i+1] + node[2*i+2];
    end

    assign tree_sum = node[0];
endmodule

// File: rtl/byte_sad_unit.sv
module byte_sad_unit
    import sad_pkg::*;
#(
    parameter int LANES    = SAD_LANES,
    parameter int LANE_W   = SAD_LANE_W,
    parameter int IDX_W    = SAD_IDX_W,
    parameter int SKIP_IDX = SAD_SKIP_IDX
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     op_valid,
    input  logic [LANES*LANE_W-1:0]  op_a,
    input  logic [LANES*LANE_W-1:0]  op_b,
    input  logic [IDX_W-1:0]         acc_sel,
    input  logic [LANES*LANE_W-1:0]  acc_val,
    output logic                     res_valid,
    output logic [LANES*LANE_W-1:0]  res_sum
);
    localparam int DATA_W  = LANES * LANE_W;
    localparam int SUM_W   = LANE_W + $clog2(LANES);
    localparam int MAX_SUM = LANES * ((1 << LANE_W) - 1);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] sum;
    } sad_state_t;

    sad_state_t state_d, state_q;

    logic [DATA_W-1:0] mag_flat;
    logic [SUM_W-1:0]  lane_total;
    logic              use_acc;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        sad_lane #(.LANE_W(LANE_W)) u_lane (
            .lane_a  (op_a[k*LANE_W +: LANE_W]),
            .lane_b  (op_b[k*LANE_W +: LANE_W]),
            .lane_mag(mag_flat[k*LANE_W +: LANE_W])
        );

        // R3: lane magnitude closes the gap between the smaller and larger byte
        a_r3_lane_mag: assert property (@(posedge clk) disable iff (!rst_n)
            (op_a[k*LANE_W +: LANE_W] >= op_b[k*LANE_W +: LANE_W])
                ? ({1'b0, op_b[k*LANE_W +: LANE_W]} + {1'b0, mag_flat[k*LANE_W +: LANE_W]}
                   == {1'b0, op_a[k*LANE_W +: LANE_W]})
                : ({1'b0, op_a[k*LANE_W +: LANE_W]} + {1'b0, mag_flat[k*LANE_W +: LANE_W]}
                   == {1'b0, op_b[k*LANE_W +: LANE_W]}));
    end

    sad_tree #(.LANES(LANES), .LANE_W(LANE_W), .SUM_W(SUM_W)) u_tree (
        .leaf_flat(mag_flat),
        .tree_sum (lane_total)
    );

    always_comb begin
        use_acc       = (acc_sel != IDX_W'(SKIP_IDX));
        state_d       = state_q;
        state_d.valid = op_valid;
        if (op_valid) begin
            state_d.sum = DATA_W'(lane_total) + (use_acc ? acc_val : '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign res_valid = state_q.valid;
    assign res_sum   = state_q.sum;

    // R2: one result flag per accepted operation, one cycle later
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid);
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !res_valid);
    // R8: idle cycles keep the result
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(res_sum));
    // R5: bare sum never exceeds the lane bound
    a_r5_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && acc_sel == IDX_W'(SKIP_IDX)) |=> (res_sum <= DATA_W'(MAX_SUM)));
endmodule

// File: tb/byte_sad_unit_bench.sv
module byte_sad_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [3:0]  acc_sel = 4'hF;
    logic [31:0] acc_val = '0;
    logic        res_valid;
    logic [31:0] res_sum;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic        exp_valid = 1'b0;
    logic [31:0] exp_sum = '0;

    always #5 clk = ~clk;

    byte_sad_unit u_byte_sad_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_a(op_a), .op_b(op_b),
        .acc_sel(acc_sel), .acc_val(acc_val), .res_valid(res_valid), .res_sum(res_sum)
    );

    function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b,
                                          input logic [3:0] sel, input logic [31:0] acc);
        longint total = 0;
        for (int k = 0; k < 4; k++) begin
            int x = int'(a[k*8 +: 8]);
            int y = int'(b[k*8 +: 8]);
            total += (x > y) ? (x - y) : (y - x);
        end
        if (sel != 4'd15) total += longint'(acc);
        return total[31:0];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive after a negedge, let one posedge pass, compare at the next negedge
    task automatic step(input string req, input logic v, input logic [31:0] a,
                        input logic [31:0] b, input logic [3:0] sel, input logic [31:0] acc);
        op_valid = v; op_a = a; op_b = b; acc_sel = sel; acc_val = acc;
        exp_valid = v;
        if (v) exp_sum = model(a, b, sel, acc);
        @(posedge clk);
        @(negedge clk);
        check({req, " valid"}, {31'b0, res_valid}, {31'b0, exp_valid});
        check({req, " sum"}, res_sum, exp_sum);
    endtask

    initial begin
        #(10 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        lfsr = 32'hACE1_2468;
        repeat (3) @(negedge clk);
        check("R1 reset valid", {31'b0, res_valid}, 32'd0);
        check("R1 reset sum", res_sum, 32'd0);
        rst_n = 1'b1;

        step("R3 mixed lanes", 1, 32'h1020_3040, 32'h0102_0304, 4'hF, 32'h0);
        check("R3 value 150", res_sum, 32'd150);
        step("R4 swapped", 1, 32'h0102_0304, 32'h1020_3040, 4'hF, 32'h0);
        check("R4 swap equal", res_sum, 32'd150);
        for (int k = 0; k < 4; k++) begin
            step("R3 single lane", 1, 32'h0000_00C8 << (8 * k), 32'h0000_0011 << (8 * k), 4'hF, 32'h0);
            check("R3 lane isolate", res_sum, 32'd183);
        end
        step("R5 max bare", 1, 32'hFFFF_FFFF, 32'h0, 4'hF, 32'h1234_5678);
        check("R5 max 1020", res_sum, 32'd1020);
        step("R6 accumulate", 1, 32'h0505_0505, 32'h0303_0303, 4'h3, 32'd1000);
        check("R6 value 1008", res_sum, 32'd1008);
        step("R6 index 14", 1, 32'h0, 32'h0, 4'hE, 32'hDEAD_BEEF);
        step("R7 wrap", 1, 32'h0000_0002, 32'h0, 4'h0, 32'hFFFF_FFFF);
        check("R7 value 1", res_sum, 32'd1);
        step("R7 max wrap", 1, 32'h00FF_00FF, 32'hFF00_FF00, 4'h7, 32'hFFFF_FF00);
        check("R7 value 0x2FC", res_sum, 32'h0000_02FC);
        step("R8 idle", 0, 32'hFFFF_FFFF, 32'h0, 4'h0, 32'h5555_5555);
        check("R8 held", res_sum, 32'h0000_02FC);
        step("R2 back to back a", 1, 32'h8000_0080, 32'h0080_8000, 4'hF, 32'h0);
        step("R2 back to back b", 1, 32'h0000_0000, 32'h0101_0101, 4'hF, 32'h0);

        for (int n = 0; n < 400; n++) begin
            logic [31:0] ra, rb, racc;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            ra = lfsr;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            rb = lfsr ^ 32'h5A5A_A5A5;
            racc = (n % 3 == 0) ? 32'hFFFF_FE00 + lfsr[8:0] : {lfsr[15:0], lfsr[31:16]};
            if (n % 5 == 0) begin
                ra = 32'hFFFF_FFFF;
                rb = 32'h0;
            end
            step("R2 R6 R7 R8 sweep", lfsr[3] | lfsr[7], ra, rb, lfsr[11:8], racc);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule